// File: doc/BRIEF.md
# Keyboard matrix scanning encoder

This block scans a key switch matrix of 8 column lines by 9 row lines (72 key positions). It raises one column line per clock and reads the row lines back. It builds a complete picture of pressed keys once per scan and compares that picture with the one from the previous scan to find keys that have just gone down. A single new key is turned into an 8-bit code by a constant lookup table, and the code is given an odd parity bit.

A downstream consumer uses a strobe and an error flag, and can also read a key-idle level. It answers with an acknowledge input and a buffer-clear input. The strobe is delayed by one whole scan after detection, which acts as a simple debounce by scan comparison. When several new keys show up together, or in back-to-back scans, the error flag is raised instead of the strobe.

A repeat mode lets the strobe follow a slow external square wave for as long as the reported key stays down.

Top module: `kbd_scan_encoder`

## Requirements
- R1: After reset, `col_drive` is one-hot with bit 0 set. It moves up by one bit each clock and returns from bit 7 to bit 0, so one scan lasts 8 clocks. The clock edge that ends the bit-7 slot is the scan-end edge.
- R2: Row input bit r is high when the key at row r of the column being driven is pressed. The key index is r*8+c. The reported code for that key is (index*37+11) mod 256.
- R3: A new key found at scan-end edge k makes `strobe` rise at scan-end edge k+1, provided no new key appears in that later scan. `strobe` then stays high until another single new key is detected or `data_ack` is seen.
- R4: `key_data` and `parity` load the new code at the edge one clock before `strobe` rises. They do not change while the strobe stays high.
- R5: Two or more new keys detected in the same scan set `error` at that scan-end edge, and no strobe follows.
- R6: A new key detected in each of two consecutive scans sets `error` at the second scan-end edge, and no strobe follows.
- R7: `error` clears at a scan-end edge that detects exactly one new key after a scan with no new key, or at a scan-end edge where no key is pressed.
- R8: `data_ack` high at a clock edge clears `strobe` and `error` at that edge. It overrides a set in the same cycle.
- R9: `buf_clr` high at a clock edge clears `key_data` and `parity` at that edge. It overrides a load in the same cycle.
- R10: Whenever `key_data` is nonzero or `parity` is high, `{key_data, parity}` has an odd number of ones.
- R11: `key_idle` is updated at each scan-end edge. It is high if that scan saw no pressed key, and it is high after reset.
- R12: With `rpt_mode` high and the reported key still pressed, `strobe` equals the latched strobe ANDed with `rpt_clk` after a two-flop synchronizer. Otherwise `strobe` is the latched strobe.
- R13: Reset (`rst_n` low) clears `strobe`, `error`, `key_data` and `parity`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_sense | input | 9 | Row return lines from the matrix |
| col_drive | output | 8 | One-hot column drive lines |
| rpt_mode | input | 1 | Selects repeat mode |
| rpt_clk | input | 1 | Slow square wave that paces repeated strobes |
| data_ack | input | 1 | Consumer acknowledge; clears strobe and error |
| buf_clr | input | 1 | Clears the output code and parity |
| key_idle | output | 1 | High when the last scan found no pressed key |
| strobe | output | 1 | Code valid indication |
| error | output | 1 | Several new keys together, or in consecutive scans |
| key_data | output | 8 | Table code of the reported key |
| parity | output | 1 | Odd parity over `key_data` |

## Verification
The hardest condition to reach from the ports is new-key detection in two consecutive scans. Detection happens when a key's column is sampled, not when the key is pressed, so two presses can land in the same scan, in adjacent scans, or further apart depending on column phase. The bench presses two keys in the same column exactly 8 clocks apart, which places them in adjacent scans. For the same-scan error it presses two keys in one column in the same clock. A behavioural model tracks the column phase itself, so every other press timing is still checked on each clock.

// File: rtl/kbd_enc_pkg.sv
package kbd_enc_pkg;
   localparam int unsigned CODE_MUL = 37;
   localparam int unsigned CODE_ADD = 11;

   // Constant lookup table, computed rather than listed
   function automatic logic [31:0] key_code(input logic [31:0] idx);
      return idx * CODE_MUL + CODE_ADD;
   endfunction
endpackage

// File: rtl/kbd_col_scan.sv
module kbd_col_scan #(
   parameter int NUM_COLS = 8,
   localparam int CW = $clog2(NUM_COLS)
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [CW-1:0]       col_idx,
   output logic [NUM_COLS-1:0] col_drive,
   output logic                scan_last,
   output logic                scan_pre
);
   logic [CW-1:0] col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          col_q <= '0;
      else if (col_q == CW'(NUM_COLS - 1)) col_q <= '0;
      else                                 col_q <= col_q + 1'b1;
   end

   always_comb begin
      col_drive        = '0;
      col_drive[col_q] = 1'b1;
   end

   assign col_idx   = col_q;
   assign scan_last = (col_q == CW'(NUM_COLS - 1));
   assign scan_pre  = (col_q == CW'(NUM_COLS - 2));
endmodule

// File: rtl/kbd_new_key.sv
module kbd_new_key #(
   parameter int NUM_ROWS = 9,
   parameter int NUM_COLS = 8,
   localparam int CW   = $clog2(NUM_COLS),
   localparam int KEYS = NUM_ROWS * NUM_COLS,
   localparam int IW   = $clog2(KEYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CW-1:0]       col_idx,
   input  logic [NUM_ROWS-1:0] row_sense,
   input  logic                scan_last,
   output logic [KEYS-1:0]     full_map,
   output logic [KEYS-1:0]     prev_map,
   output logic                new_any,
   output logic                new_multi,
   output logic [IW-1:0]       new_idx
);
   logic [KEYS-1:0] acc_q, prev_q, new_bits;

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
         assign full_map[r*NUM_COLS+c] = (col_idx == CW'(c)) ? row_sense[r]
                                                             : acc_q[r*NUM_COLS+c];
      end
   end

   assign new_bits  = full_map & ~prev_q;
   assign new_any   = |new_bits;
   assign new_multi = |(new_bits & (new_bits - 1'b1));

   always_comb begin
      new_idx = '0;
      for (int k = KEYS - 1; k >= 0; k--)
         if (new_bits[k]) new_idx = IW'(k);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         prev_q <= '0;
      end else begin
         acc_q <= full_map;
         if (scan_last) prev_q <= full_map;
      end
   end

   assign prev_map = prev_q;
endmodule

// File: rtl/kbd_handshake.sv
module kbd_handshake #(
   parameter int KEYS        = 72,
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int IW = $clog2(KEYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_last,
   input  logic              scan_pre,
   input  logic              new_any,
   input  logic              new_multi,
   input  logic [IW-1:0]     new_idx,
   input  logic [KEYS-1:0]   full_map,
   input  logic [KEYS-1:0]   prev_map,
   input  logic              rpt_mode,
   input  logic              rpt_clk,
   input  logic              data_ack,
   input  logic              buf_clr,
   output logic              strobe,
   output logic              error,
   output logic [CODE_W-1:0] key_data,
   output logic              parity,
   output logic              key_idle
);
   logic              strb_q, err_q, pend_q, last_new_q, idle_q, par_q, rpt_s;
   logic [IW-1:0]     pidx_q, kidx_q;
   logic [CODE_W-1:0] data_q, code_w;

   // Repeat clock: bypass when already synchronous, else a flop chain
   if (SYNC_STAGES == 0) begin : g_rpt_direct
      assign rpt_s = rpt_clk;
   end else begin : g_rpt_sync
      logic [SYNC_STAGES-1:0] sy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sy_q <= '0;
         else        sy_q <= {sy_q[SYNC_STAGES-2:0], rpt_clk};
      end
      assign rpt_s = sy_q[SYNC_STAGES-1];
   end

   assign code_w = CODE_W'(kbd_enc_pkg::key_code(32'(pidx_q)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q <= 1'b0;  err_q <= 1'b0;  pend_q <= 1'b0;  last_new_q <= 1'b0;
         pidx_q <= '0;    kidx_q <= '0;   idle_q <= 1'b1;
      end else begin
         if (scan_last) begin
            if (new_multi || (new_any && last_new_q)) begin
               err_q  <= 1'b1;
               pend_q <= 1'b0;
            end else if (new_any) begin
               pend_q <= 1'b1;
               pidx_q <= new_idx;
               err_q  <= 1'b0;
               strb_q <= 1'b0;
            end else begin
               if (pend_q) begin
                  strb_q <= 1'b1;
                  pend_q <= 1'b0;
                  kidx_q <= pidx_q;
               end
               if (!(|full_map)) err_q <= 1'b0;
            end
            last_new_q <= new_any;
            idle_q     <= ~(|full_map);
         end
         if (data_ack) begin
            strb_q <= 1'b0;
            err_q  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         par_q  <= 1'b0;
      end else if (buf_clr) begin
         data_q <= '0;
         par_q  <= 1'b0;
      end else if (scan_pre && pend_q) begin
         data_q <= code_w;
         par_q  <= ~(^code_w);
      end
   end

   assign strobe   = strb_q & (~rpt_mode | ~prev_map[kidx_q] | rpt_s);
   assign error    = err_q;
   assign key_data = data_q;
   assign parity   = par_q;
   assign key_idle = idle_q;
endmodule

// File: rtl/kbd_scan_encoder.sv
module kbd_scan_encoder #(
   parameter int NUM_ROWS    = 9,
   parameter int NUM_COLS    = 8,
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_ROWS-1:0] row_sense,
   output logic [NUM_COLS-1:0] col_drive,
   input  logic                rpt_mode,
   input  logic                rpt_clk,
   input  logic                data_ack,
   input  logic                buf_clr,
   output logic                key_idle,
   output logic                strobe,
   output logic                error,
   output logic [CODE_W-1:0]   key_data,
   output logic                parity
);
   localparam int CW   = $clog2(NUM_COLS);
   localparam int KEYS = NUM_ROWS * NUM_COLS;
   localparam int IW   = $clog2(KEYS);

   if (NUM_COLS < 2) begin : g_bad_cols
      $error("NUM_COLS must be at least 2");
   end
   if (NUM_ROWS < 1) begin : g_bad_rows
      $error("NUM_ROWS must be at least 1");
   end
   if (SYNC_STAGES == 1) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 or at least 2");
   end

   logic [CW-1:0]   col_idx;
   logic            scan_last, scan_pre, new_any, new_multi;
   logic [IW-1:0]   new_idx;
   logic [KEYS-1:0] full_map, prev_map;

   kbd_col_scan #(.NUM_COLS(NUM_COLS)) u_scan (
      .clk(clk), .rst_n(rst_n), .col_idx(col_idx), .col_drive(col_drive),
      .scan_last(scan_last), .scan_pre(scan_pre)
   );

   kbd_new_key #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_newkey (
      .clk(clk), .rst_n(rst_n), .col_idx(col_idx), .row_sense(row_sense),
      .scan_last(scan_last), .full_map(full_map), .prev_map(prev_map),
      .new_any(new_any), .new_multi(new_multi), .new_idx(new_idx)
   );

   kbd_handshake #(.KEYS(KEYS), .CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) u_hs (
      .clk(clk), .rst_n(rst_n), .scan_last(scan_last), .scan_pre(scan_pre),
      .new_any(new_any), .new_multi(new_multi), .new_idx(new_idx),
      .full_map(full_map), .prev_map(prev_map), .rpt_mode(rpt_mode),
      .rpt_clk(rpt_clk), .data_ack(data_ack), .buf_clr(buf_clr),
      .strobe(strobe), .error(error), .key_data(key_data), .parity(parity),
      .key_idle(key_idle)
   );
endmodule

// File: rtl/kbd_scan_encoder_chk.sv
module kbd_scan_encoder_chk #(
   parameter int NUM_COLS = 8,
   parameter int CODE_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_COLS-1:0] col_drive,
   input logic                rpt_mode,
   input logic                data_ack,
   input logic                buf_clr,
   input logic                strobe,
   input logic                error,
   input logic [CODE_W-1:0]   key_data,
   input logic                parity
);
   AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col_drive) == 1);                                             // R1
   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !col_drive[NUM_COLS-1] |=> (col_drive == ($past(col_drive) << 1)));      // R1
   AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      col_drive[NUM_COLS-1] |=> col_drive[0]);                                 // R1
   AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(strobe) && !rpt_mode && !$past(buf_clr)) |-> $stable(key_data));  // R4
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      data_ack |=> (!strobe && !error));                                       // R8
   AST_BUF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      buf_clr |=> (key_data == '0 && !parity));                                // R9
   AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (key_data != '0 || parity) |-> (^{key_data, parity}));                   // R10
endmodule

bind kbd_scan_encoder kbd_scan_encoder_chk #(.NUM_COLS(NUM_COLS), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .col_drive(col_drive), .rpt_mode(rpt_mode),
   .data_ack(data_ack), .buf_clr(buf_clr), .strobe(strobe), .error(error),
   .key_data(key_data), .parity(parity)
);

// File: tb/kbd_scan_encoder_tb.sv
module kbd_scan_encoder_tb;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic [8:0] row_sense;
   logic [7:0] col_drive, key_data;
   logic       rpt_mode = 0, rpt_clk = 0, data_ack = 0, buf_clr = 0;
   logic       key_idle, strobe, error, parity;
   bit         keys [9][8];
   int         errors = 0, checks = 0;
   bit         done = 0;

   always #2 clk = ~clk;

   kbd_scan_encoder u_dut (
      .clk(clk), .rst_n(rst_n), .row_sense(row_sense), .col_drive(col_drive),
      .rpt_mode(rpt_mode), .rpt_clk(rpt_clk), .data_ack(data_ack), .buf_clr(buf_clr),
      .key_idle(key_idle), .strobe(strobe), .error(error), .key_data(key_data),
      .parity(parity)
   );

   // Matrix model: row r reads high if a key is down in any driven column
   always_comb
      for (int r = 0; r < 9; r++) begin
         row_sense[r] = 1'b0;
         for (int c = 0; c < 8; c++)
            if (col_drive[c] && keys[r][c]) row_sense[r] = 1'b1;
      end

   function automatic logic [7:0] tbl(input int idx);
      return 8'((idx * 37 + 11) % 256);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [71:0] m_acc = '0, m_prev = '0, f, nw;
   int   m_col = 0, m_pidx = 0, m_kidx = 0, n, fi;
   bit   m_strb = 0, m_err = 0, m_pend = 0, m_last = 0, m_par = 0, m_idle = 1;
   bit   ns, ne, np;
   logic [7:0] m_data = '0;
   bit   [1:0] m_sync = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_col = 0; m_acc = '0; m_prev = '0; m_strb = 0; m_err = 0; m_pend = 0;
         m_last = 0; m_pidx = 0; m_kidx = 0; m_data = '0; m_par = 0; m_idle = 1;
         m_sync = '0;
      end else begin
         f = m_acc;
         for (int r = 0; r < 9; r++) f[r*8+m_col] = keys[r][m_col];
         nw = f & ~m_prev;
         n = 0; fi = -1;
         for (int k = 0; k < 72; k++)
            if (nw[k]) begin n++; if (fi < 0) fi = k; end
         ns = m_strb; ne = m_err; np = m_pend;
         if (buf_clr) begin m_data = '0; m_par = 0; end
         else if (m_col == 6 && m_pend) begin m_data = tbl(m_pidx); m_par = ~(^tbl(m_pidx)); end
         if (m_col == 7) begin
            if (n >= 2 || (n == 1 && m_last)) begin ne = 1; np = 0; end
            else if (n == 1) begin np = 1; m_pidx = fi; ne = 0; ns = 0; end
            else begin
               if (m_pend) begin ns = 1; np = 0; m_kidx = m_pidx; end
               if (f == '0) ne = 0;
            end
            m_last = (n != 0);
            m_prev = f;
            m_idle = (f == '0);
         end
         if (data_ack) begin ns = 0; ne = 0; end
         m_strb = ns; m_err = ne; m_pend = np;
         m_acc = f;
         m_col = (m_col + 1) % 8;
         m_sync = {m_sync[0], rpt_clk};
      end
   end

   // Compare every output on every falling edge
   always @(negedge clk) begin
      bit es;
      es = m_strb && (!rpt_mode || !m_prev[m_kidx] || m_sync[1]);
      chk(col_drive == 8'(1 << m_col), "R1 col_drive", col_drive, 1 << m_col);
      chk(strobe == es,   "R3/R12 strobe", strobe, es);
      chk(error == m_err, "R5/R6/R7 error", error, m_err);
      chk(key_data == m_data, "R2/R4 key_data", key_data, m_data);
      chk(parity == m_par, "R10 parity", parity, m_par);
      chk(key_idle == m_idle, "R11 key_idle", key_idle, m_idle);
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic release_all();
      foreach (keys[r, c]) keys[r][c] = 0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R13 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int toggles;
      bit prev_s;
      release_all();
      @(negedge clk);
      chk(!strobe && !error && key_data == 0 && !parity, "R13 reset outputs",
          {strobe, error, parity}, 0);
      chk(key_idle == 1, "R11 idle after reset", key_idle, 1);
      step(2); rst_n = 1; step(5);

      // single key, row 2 col 3 -> index 19 -> code ca
      keys[2][3] = 1; step(32);
      @(negedge clk);
      chk(strobe == 1, "R3 strobe after single key", strobe, 1);
      chk(key_data == 8'hca, "R2 code of key 19", key_data, 8'hca);
      chk(parity == 1, "R10 parity of ca", parity, 1);
      chk(key_idle == 0, "R11 idle low while held", key_idle, 0);
      step(1); data_ack = 1; step(1); data_ack = 0;
      @(negedge clk);
      chk(strobe == 0, "R8 ack clears strobe", strobe, 0);
      step(1); buf_clr = 1; step(1); buf_clr = 0;
      @(negedge clk);
      chk(key_data == 0 && parity == 0, "R9 buffer clear", key_data, 0);
      release_all(); step(24);

      // two keys in the same column and cycle -> same scan
      keys[0][2] = 1; keys[6][2] = 1; step(32);
      @(negedge clk);
      chk(error == 1 && strobe == 0, "R5 multi key error", {error, strobe}, 2);
      step(1); release_all(); step(24);
      @(negedge clk);
      chk(error == 0, "R7 release clears error", error, 1'b0);

      // same column, 8 clocks apart -> consecutive scans
      step(3); keys[1][4] = 1; step(8); keys[5][4] = 1; step(32);
      @(negedge clk);
      chk(error == 1 && strobe == 0, "R6 consecutive error", {error, strobe}, 2);
      step(1); keys[3][5] = 1; step(32);
      @(negedge clk);
      chk(error == 0 && strobe == 1, "R7 single key clears error", {error, strobe}, 1);
      step(1); keys[7][0] = 1; step(16);
      @(negedge clk);
      chk(strobe == 0 || key_data == tbl(56), "R3 new key replaces strobe", key_data, tbl(56));
      step(1); release_all(); step(24);

      // ack held across detection: strobe never rises
      data_ack = 1; keys[8][6] = 1; step(40);
      @(negedge clk);
      chk(strobe == 0, "R8 ack overrides set", strobe, 0);
      step(1); data_ack = 0; release_all(); step(24);

      // buffer clear held across load
      buf_clr = 1; keys[4][4] = 1; step(40);
      @(negedge clk);
      chk(key_data == 0 && parity == 0, "R9 clear overrides load", key_data, 0);
      step(1); buf_clr = 0; release_all(); data_ack = 1; step(1); data_ack = 0; step(24);

      // repeat mode
      rpt_mode = 1; keys[4][1] = 1;
      toggles = 0; prev_s = strobe;
      for (int i = 0; i < 240; i++) begin
         if (i % 12 == 0) rpt_clk = ~rpt_clk;
         step(1);
         @(negedge clk);
         if (strobe != prev_s) toggles++;
         prev_s = strobe;
      end
      chk(toggles >= 6, "R12 strobe follows repeat clock", toggles, 6);
      step(1); release_all(); step(24);
      @(negedge clk);
      chk(strobe == 1, "R12 released key ends gating", strobe, 1);
      step(1); rpt_mode = 0; step(8);

      done = 1;
      summary();
      $finish;
   end
endmodule